// File: doc/BRIEF.md
# Protected-Mode Interrupt Entry Sequencer

This block runs between two instructions whenever an interrupt or exception is waiting. It takes an 8-bit vector and an event kind, and fetches the matching gate from the interrupt table in memory. The gate's selector points at a code-segment descriptor in the global table, and the block fetches that too. It then checks privilege. If the handler runs at a more privileged level than the interrupted code, it takes the new stack pointer and stack segment from the task-state area. It pushes the return state and hands back the handler's code selector and entry point.

All memory traffic goes through one 32-bit port with a request valid/ready handshake. A read is followed by exactly one response. A write completes when the port accepts it. The core supplies the current register values and latches the new values from the outputs on the done pulse. A privilege violation ends the sequence with a general-protection indication instead. In that case nothing is written and every register output keeps its entry value.

Top module: `intrseq_top`

## Requirements
- R1: `holdIssue` is high in every cycle in which `evtValid` or `busy` is high, and low otherwise, so the next instruction cannot start while an event waits or is being entered.
- R2: The gate is read as two words at `idtBase + 8*vector` and `+4`. In word 0, bits [15:0] are offset low and bits [31:16] are the selector. In word 1, bits [31:16] are offset high and bits [14:13] are the gate privilege level.
- R3: The code descriptor is read as two words at `gdtBase + 8*selector[15:3]` and `+4`. Word 0 is the segment base, driven on `codeBase` once the sequence ends. Bits [14:13] of word 1 are the segment privilege level (DPL).
- R4: With CPL = `curCs[1:0]`, CPL numerically below the segment DPL ends the sequence with `gpFault` high in the done cycle. No memory write is made, and `newCs`, `newEip`, `newSs` and `newEsp` equal the entry CS, EIP, SS and ESP.
- R5: For software-raised events (kind code 1) only, a gate privilege level numerically below CPL also raises the fault of R4. Kinds 0 (external), 2 (fault) and 3 (trap) skip this check.
- R6: When CPL differs from the segment DPL, the new ESP is read at `tssBase + 4 + 8*DPL` and the new SS at `tssBase + 8 + 8*DPL`. The old SS and then the old ESP are pushed onto the new stack before anything else.
- R7: After any stack switch, EFLAGS, CS and the return EIP are pushed in that order, then `errCode` only when `errValid` is set. Each push first lowers ESP by 4 and writes at the lowered address. SS and CS are zero-extended to 32 bits.
- R8: The pushed return EIP is `faultEip` for kind 2 (fault) and `curEip` for every other kind.
- R9: On success, `newCs` is the gate selector with its low two bits replaced by the segment DPL and `newEip` is the gate offset. `newEsp` is the stack pointer after the last push, and `newSs` is the task-state SS if the stack was switched, else `curSs`.
- R10: `busy` rises in the cycle after an event is accepted and stays high through the single-cycle `done` pulse. An event presented while `busy` is high, including the done cycle, starts nothing.
- R11: A memory request holds its address, direction and write data until `memReqReady` is seen. Each read waits for its `memRspValid` before the next access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Interrupt or exception pending at the instruction boundary |
| evtVector | input | 8 | Event vector 0..255 |
| evtKind | input | 2 | 0 external, 1 software, 2 fault, 3 trap |
| errValid | input | 1 | Event carries an error code |
| errCode | input | 32 | Error code to push |
| curCs | input | 16 | Current code selector (low two bits are CPL) |
| curEip | input | 32 | Address of the next instruction |
| faultEip | input | 32 | Address of the faulting instruction |
| curEflags | input | 32 | Current flags |
| curSs | input | 16 | Current stack selector |
| curEsp | input | 32 | Current stack pointer |
| idtBase | input | 32 | Interrupt table base address |
| gdtBase | input | 32 | Global descriptor table base address |
| tssBase | input | 32 | Task-state area base address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqAddr | output | 32 | Byte address of the word |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read response valid |
| memRspRdata | input | 32 | Read response data |
| holdIssue | output | 1 | Blocks the next instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| gpFault | output | 1 | General-protection fault, valid with done |
| newCs | output | 16 | Handler code selector |
| newEip | output | 32 | Handler entry point |
| newSs | output | 16 | Stack selector after entry |
| newEsp | output | 32 | Stack pointer after entry |
| codeBase | output | 32 | Base of the handler code segment |

## Verification
Two events can meet in one cycle: the done pulse of one sequence and a newly raised pending event. The bench raises `evtValid` with a different vector in exactly the done cycle, and in other runs partway through a sequence. It judges the result by three things. `busy` must fall and stay low with no further memory request. The finished entry's stack contents and register outputs must match the first event alone. The following event must be entered normally. Both privilege checks can also fail in the same decision cycle; the sweep over every vector, CPL and kind drives that case and expects a single fault with no writes.

// File: rtl/intrseq_pkg.sv
package intrseq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int SEL_W = 16;
  localparam int VEC_W = 8;
  localparam int PL_W = 2;
  // table geometry
  localparam int ENTRY_BYTES = 8;
  localparam int WORD_BYTES = 4;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam int TSS_ESP_OFS = 4;
  localparam int TSS_SS_OFS = 8;
  localparam int TSS_STRIDE = 8;
  localparam int TSS_SHIFT = $clog2(TSS_STRIDE);
  // descriptor field positions
  localparam int OFS_HALF = 16;
  localparam int GATE_SEL_LSB = 16;
  localparam int DPL_LSB = 13;
  localparam int SEL_IDX_LSB = 3;
  // push list
  localparam int PUSH_MAX = 6;
  localparam int IDX_W = $clog2(PUSH_MAX);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [PL_W-1:0] pl_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_SS = idx_t'(0);
  localparam idx_t IDX_ESP = idx_t'(1);
  localparam idx_t IDX_EFLAGS = idx_t'(2);
  localparam idx_t IDX_CS = idx_t'(3);
  localparam idx_t IDX_EIP = idx_t'(4);
  localparam idx_t IDX_ERR = idx_t'(5);

  typedef enum logic [1:0] {
    KIND_EXT = 2'd0,
    KIND_SOFT = 2'd1,
    KIND_FAULT = 2'd2,
    KIND_TRAP = 2'd3
  } evtKind_e;

  typedef enum logic [2:0] {
    ADDR_GATE0,
    ADDR_GATE1,
    ADDR_SEG0,
    ADDR_SEG1,
    ADDR_TSSESP,
    ADDR_TSSSS,
    ADDR_PUSH
  } addrSel_e;

  typedef struct packed {
    logic latchEvt;
    logic ldGate0;
    logic ldGate1;
    logic ldSeg0;
    logic ldSeg1;
    logic ldTssEsp;
    logic ldTssSs;
    logic startPush;
    logic pushStep;
    logic setGp;
    addrSel_e addrSel;
  } seqStrobe_t;

  typedef struct packed {
    logic privFail;
    logic needSwitch;
    logic pushLast;
    logic gpSet;
  } seqStatus_t;
endpackage

// File: rtl/intrseq_datapath.sv
module intrseq_datapath
  import intrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output seqStatus_t sts,
  input  vec_t       evtVector,
  input  logic [1:0] evtKind,
  input  logic       errValid,
  input  data_t      errCode,
  input  sel_t       curCs,
  input  data_t      curEip,
  input  data_t      faultEip,
  input  data_t      curEflags,
  input  sel_t       curSs,
  input  data_t      curEsp,
  input  addr_t      idtBase,
  input  addr_t      gdtBase,
  input  addr_t      tssBase,
  input  data_t      memRspRdata,
  output addr_t      memReqAddr,
  output data_t      memReqWdata,
  output sel_t       newCs,
  output data_t      newEip,
  output sel_t       newSs,
  output data_t      newEsp,
  output addr_t      codeBase
);
  // latched entry state
  vec_t vecR;
  logic [1:0] kindR;
  logic errValidR;
  data_t errCodeR;
  sel_t csR;
  data_t eipR;
  data_t retEipR;
  data_t eflagsR;
  sel_t ssR;
  data_t espR;
  addr_t idtR, gdtR, tssR;
  // fetched descriptor state
  logic [SEL_W-1:PL_W] selR;
  data_t offR;
  pl_t gateDplR;
  addr_t segBaseR;
  pl_t segDplR;
  data_t tssEspR;
  sel_t tssSsR;
  // push state
  data_t espWork;
  idx_t pushIdx;
  logic gpR;

  pl_t cpl;
  idx_t lastIdx;
  addr_t gateAddr, segAddr, tssSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecR <= '0; kindR <= '0; errValidR <= 1'b0; errCodeR <= '0;
      csR <= '0; eipR <= '0; retEipR <= '0; eflagsR <= '0;
      ssR <= '0; espR <= '0; idtR <= '0; gdtR <= '0; tssR <= '0;
      selR <= '0; offR <= '0; gateDplR <= '0; segBaseR <= '0; segDplR <= '0;
      tssEspR <= '0; tssSsR <= '0; espWork <= '0; pushIdx <= '0; gpR <= 1'b0;
    end else begin
      if (stb.latchEvt) begin
        vecR <= evtVector;
        kindR <= evtKind;
        errValidR <= errValid;
        errCodeR <= errCode;
        csR <= curCs;
        eipR <= curEip;
        retEipR <= (evtKind == KIND_FAULT) ? faultEip : curEip;
        eflagsR <= curEflags;
        ssR <= curSs;
        espR <= curEsp;
        idtR <= idtBase;
        gdtR <= gdtBase;
        tssR <= tssBase;
        gpR <= 1'b0;
      end
      if (stb.ldGate0) begin
        offR[OFS_HALF-1:0] <= memRspRdata[OFS_HALF-1:0];
        selR <= memRspRdata[GATE_SEL_LSB+PL_W +: SEL_W-PL_W];
      end
      if (stb.ldGate1) begin
        offR[DATA_W-1:OFS_HALF] <= memRspRdata[DATA_W-1:OFS_HALF];
        gateDplR <= memRspRdata[DPL_LSB +: PL_W];
      end
      if (stb.ldSeg0) segBaseR <= memRspRdata;
      if (stb.ldSeg1) segDplR <= memRspRdata[DPL_LSB +: PL_W];
      if (stb.startPush) begin
        pushIdx <= sts.needSwitch ? IDX_SS : IDX_EFLAGS;
        espWork <= espR;
      end
      if (stb.ldTssEsp) begin
        tssEspR <= memRspRdata;
        espWork <= memRspRdata;
      end
      if (stb.ldTssSs) tssSsR <= memRspRdata[SEL_W-1:0];
      if (stb.pushStep) begin
        espWork <= espWork - data_t'(WORD_BYTES);
        pushIdx <= pushIdx + idx_t'(1);
      end
      if (stb.setGp) gpR <= 1'b1;
    end
  end

  // privilege decisions
  assign cpl = csR[PL_W-1:0];
  assign lastIdx = errValidR ? IDX_ERR : IDX_EIP;
  assign sts.privFail = (cpl < segDplR) || ((kindR == KIND_SOFT) && (gateDplR < cpl));
  assign sts.needSwitch = (cpl != segDplR);
  assign sts.pushLast = (pushIdx == lastIdx);
  assign sts.gpSet = gpR;

  // address generation
  assign gateAddr = idtR + (addr_t'(vecR) << ENTRY_SHIFT);
  assign segAddr = gdtR + (addr_t'(selR[SEL_W-1:SEL_IDX_LSB]) << ENTRY_SHIFT);
  assign tssSlot = tssR + (addr_t'(segDplR) << TSS_SHIFT);

  always_comb begin
    unique case (stb.addrSel)
      ADDR_GATE0: memReqAddr = gateAddr;
      ADDR_GATE1: memReqAddr = gateAddr + addr_t'(WORD_BYTES);
      ADDR_SEG0: memReqAddr = segAddr;
      ADDR_SEG1: memReqAddr = segAddr + addr_t'(WORD_BYTES);
      ADDR_TSSESP: memReqAddr = tssSlot + addr_t'(TSS_ESP_OFS);
      ADDR_TSSSS: memReqAddr = tssSlot + addr_t'(TSS_SS_OFS);
      ADDR_PUSH: memReqAddr = espWork - addr_t'(WORD_BYTES);
      default: memReqAddr = gateAddr;
    endcase
  end

  // push data by list position
  always_comb begin
    unique case (pushIdx)
      IDX_SS: memReqWdata = data_t'(ssR);
      IDX_ESP: memReqWdata = espR;
      IDX_EFLAGS: memReqWdata = eflagsR;
      IDX_CS: memReqWdata = data_t'(csR);
      IDX_EIP: memReqWdata = retEipR;
      default: memReqWdata = errCodeR;
    endcase
  end

  // results
  assign newCs = gpR ? csR : {selR, segDplR};
  assign newEip = gpR ? eipR : offR;
  assign newSs = (!gpR && sts.needSwitch) ? tssSsR : ssR;
  assign newEsp = gpR ? espR : espWork;
  assign codeBase = segBaseR;
endmodule

// File: rtl/intrseq_ctrl.sv
module intrseq_ctrl
  import intrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  seqStatus_t sts,
  output seqStrobe_t stb,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       busy,
  output logic       done,
  output logic       gpFault
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_GATE0, ST_GATE1, ST_SEG0, ST_SEG1,
    ST_CHECK, ST_TSSESP, ST_TSSSS, ST_PUSH, ST_DONE
  } state_e;

  state_e state, nextState;
  logic waitRsp, nextWait;
  logic isRead, rdDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      waitRsp <= 1'b0;
    end else begin
      state <= nextState;
      waitRsp <= nextWait;
    end
  end

  assign isRead = (state == ST_GATE0) || (state == ST_GATE1) || (state == ST_SEG0) ||
                  (state == ST_SEG1) || (state == ST_TSSESP) || (state == ST_TSSSS);
  assign rdDone = isRead && waitRsp && memRspValid;

  always_comb begin
    stb = '0;
    stb.addrSel = ADDR_GATE0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    nextState = state;
    nextWait = waitRsp;
    // shared read handshake: issue, then wait for the single response
    if (isRead) begin
      if (!waitRsp) begin
        memReqValid = 1'b1;
        if (memReqReady) nextWait = 1'b1;
      end else if (memRspValid) begin
        nextWait = 1'b0;
      end
    end
    unique case (state)
      ST_IDLE: begin
        if (evtValid) begin
          stb.latchEvt = 1'b1;
          nextState = ST_GATE0;
        end
      end
      ST_GATE0: begin
        stb.addrSel = ADDR_GATE0;
        stb.ldGate0 = rdDone;
        if (rdDone) nextState = ST_GATE1;
      end
      ST_GATE1: begin
        stb.addrSel = ADDR_GATE1;
        stb.ldGate1 = rdDone;
        if (rdDone) nextState = ST_SEG0;
      end
      ST_SEG0: begin
        stb.addrSel = ADDR_SEG0;
        stb.ldSeg0 = rdDone;
        if (rdDone) nextState = ST_SEG1;
      end
      ST_SEG1: begin
        stb.addrSel = ADDR_SEG1;
        stb.ldSeg1 = rdDone;
        if (rdDone) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (sts.privFail) begin
          stb.setGp = 1'b1;
          nextState = ST_DONE;
        end else begin
          stb.startPush = 1'b1;
          nextState = sts.needSwitch ? ST_TSSESP : ST_PUSH;
        end
      end
      ST_TSSESP: begin
        stb.addrSel = ADDR_TSSESP;
        stb.ldTssEsp = rdDone;
        if (rdDone) nextState = ST_TSSSS;
      end
      ST_TSSSS: begin
        stb.addrSel = ADDR_TSSSS;
        stb.ldTssSs = rdDone;
        if (rdDone) nextState = ST_PUSH;
      end
      ST_PUSH: begin
        stb.addrSel = ADDR_PUSH;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          stb.pushStep = 1'b1;
          if (sts.pushLast) nextState = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign gpFault = done && sts.gpSet;
endmodule

// File: rtl/intrseq_top.sv
module intrseq_top
  import intrseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [7:0]  evtVector,
  input  logic [1:0]  evtKind,
  input  logic        errValid,
  input  logic [31:0] errCode,
  input  logic [15:0] curCs,
  input  logic [31:0] curEip,
  input  logic [31:0] faultEip,
  input  logic [31:0] curEflags,
  input  logic [15:0] curSs,
  input  logic [31:0] curEsp,
  input  logic [31:0] idtBase,
  input  logic [31:0] gdtBase,
  input  logic [31:0] tssBase,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  input  logic        memRspValid,
  input  logic [31:0] memRspRdata,
  output logic        holdIssue,
  output logic        busy,
  output logic        done,
  output logic        gpFault,
  output logic [15:0] newCs,
  output logic [31:0] newEip,
  output logic [15:0] newSs,
  output logic [31:0] newEsp,
  output logic [31:0] codeBase
);
  seqStrobe_t stb;
  seqStatus_t sts;

  intrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .sts(sts), .stb(stb), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .busy(busy), .done(done), .gpFault(gpFault)
  );

  intrseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .evtVector(evtVector), .evtKind(evtKind), .errValid(errValid), .errCode(errCode),
    .curCs(curCs), .curEip(curEip), .faultEip(faultEip), .curEflags(curEflags),
    .curSs(curSs), .curEsp(curEsp), .idtBase(idtBase), .gdtBase(gdtBase),
    .tssBase(tssBase), .memRspRdata(memRspRdata),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .newCs(newCs), .newEip(newEip), .newSs(newSs), .newEsp(newEsp), .codeBase(codeBase)
  );

  // the next instruction may not issue while an event waits or is entered
  assign holdIssue = evtValid | busy;
endmodule

// File: rtl/intrseq_checker.sv
module intrseq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        gpFault,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic [31:0] memReqWdata
);
  logic [2:0] wrCnt;
  logic [31:0] lastWrAddr;
  logic wrFire;

  assign wrFire = memReqValid && memReqReady && memReqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt <= '0;
      lastWrAddr <= '0;
    end else if (done) begin
      wrCnt <= '0;
    end else if (wrFire) begin
      wrCnt <= wrCnt + 3'd1;
      lastWrAddr <= memReqAddr;
    end
  end

  // R11: a stalled request keeps its address, direction and data
  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) &&
    $stable(memReqWrite) && $stable(memReqWdata));

  // R10: done is a single pulse followed by idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  // R10: no memory traffic outside a sequence
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  // R4: a protection fault leaves memory untouched
  p_gp_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> wrCnt == 3'd0);

  // R7: every push after the first lands one word lower
  p_push_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrFire && wrCnt != 3'd0 |-> memReqAddr == lastWrAddr - 32'd4);

  // R7: a successful entry makes between three and six pushes
  p_push_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    done && !gpFault |-> wrCnt >= 3'd3 && wrCnt <= 3'd6);
endmodule

bind intrseq_top intrseq_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .gpFault(gpFault),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .memReqWdata(memReqWdata)
);

// File: tb/sim_intrseq_top.sv
`timescale 1ns/1ps
module sim_intrseq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [7:0] evtVector = '0;
  logic [1:0] evtKind = '0;
  logic errValid = 1'b0;
  logic [31:0] errCode = '0;
  logic [15:0] curCs = '0;
  logic [31:0] curEip = '0;
  logic [31:0] faultEip = '0;
  logic [31:0] curEflags = '0;
  logic [15:0] curSs = '0;
  logic [31:0] curEsp = '0;
  logic [31:0] idtBase = 32'h0000_0000;
  logic [31:0] gdtBase = 32'h0000_0800;
  logic [31:0] tssBase = 32'h0000_0900;
  logic memReqValid, memReqWrite, memReqReady, memRspValid;
  logic [31:0] memReqAddr, memReqWdata, memRspRdata;
  logic holdIssue, busy, done, gpFault;
  logic [15:0] newCs, newSs;
  logic [31:0] newEip, newEsp, codeBase;

  int checks = 0;
  int failures = 0;
  int wrCount;
  logic stallMode = 1'b0;
  logic [15:0] lfsr;
  logic [31:0] mem [0:1023];

  always #5 clk = ~clk;

  intrseq_top u0 (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtVector(evtVector),
    .evtKind(evtKind), .errValid(errValid), .errCode(errCode), .curCs(curCs),
    .curEip(curEip), .faultEip(faultEip), .curEflags(curEflags), .curSs(curSs),
    .curEsp(curEsp), .idtBase(idtBase), .gdtBase(gdtBase), .tssBase(tssBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspRdata(memRspRdata), .holdIssue(holdIssue), .busy(busy), .done(done),
    .gpFault(gpFault), .newCs(newCs), .newEip(newEip), .newSs(newSs),
    .newEsp(newEsp), .codeBase(codeBase)
  );

  function automatic logic [31:0] gateOff(int g);
    return 32'h0040_0000 + 32'(g) * 32'h0001_0101;
  endfunction
  function automatic logic [31:0] tssEsp(int d);
    return 32'h0000_0A40 + 32'(d) * 32'h40;
  endfunction
  function automatic logic [15:0] tssSs(int d);
    return 16'(32'h30 + 9 * d);
  endfunction

  function automatic logic [31:0] memInit(int w);
    int a;
    a = w * 4;
    if (a < 'h800) begin
      int g;
      logic [31:0] off;
      g = a >> 3;
      off = gateOff(g);
      if ((a & 4) == 0) return {16'(((g & 3) + 1) << 3), off[15:0]};
      return {off[31:16], 1'b1, 2'((g >> 2) & 3), 13'h0};
    end
    if (a >= 'h800 && a < 'h828) begin
      int k;
      k = (a - 'h800) >> 3;
      if ((a & 4) == 0) return 32'h0001_0000 * 32'(k);
      return {16'h0, 1'b1, 2'((k == 0) ? 0 : k - 1), 13'h0};
    end
    if (a >= 'h900 && a < 'h928) begin
      for (int d = 0; d < 4; d++) begin
        if (a - 'h900 == 4 + 8 * d) return tssEsp(d);
        if (a - 'h900 == 8 + 8 * d) return 32'(tssSs(d));
      end
    end
    return 32'h0;
  endfunction

  // memory model: one-cycle read response, optional random stalls
  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 1024; w++) mem[w] <= memInit(w);
      memRspValid <= 1'b0;
      memRspRdata <= '0;
      memReqReady <= 1'b1;
      wrCount <= 0;
      lfsr <= 16'hACE1;
    end else begin
      memRspValid <= 1'b0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr[11:2]] <= memReqWdata;
          wrCount <= wrCount + 1;
        end else begin
          memRspRdata <= mem[memReqAddr[11:2]];
          memRspValid <= 1'b1;
        end
      end
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memReqReady <= stallMode ? lfsr[0] : 1'b1;
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runEvent(input int g, input int cpl, input int inject);
    int segDpl, gateDpl, kind, nPush, wrBefore, cycles;
    logic errV, gp, sw;
    logic [31:0] startEsp, retEip;
    logic [31:0] items [0:5];
    segDpl = g & 3;
    gateDpl = (g >> 2) & 3;
    kind = (g >> 4) & 3;
    errV = 1'(((g >> 3) ^ (g >> 6)) & 1);
    gp = (cpl < segDpl) || (kind == 1 && gateDpl < cpl);
    sw = (cpl != segDpl);
    startEsp = sw ? tssEsp(segDpl) : 32'h0000_0C00;

    @(negedge clk);
    evtVector = 8'(g);
    evtKind = 2'(kind);
    errValid = errV;
    errCode = 32'hE000_0000 | 32'(g);
    curCs = 16'h0100 | 16'(cpl);
    curEip = 32'h0000_4000 + 32'(g);
    faultEip = 32'h0000_3F00 + 32'(g);
    curEflags = 32'h0000_0202 ^ 32'(g);
    curSs = 16'h0200 | 16'(cpl);
    curEsp = 32'h0000_0C00;
    retEip = (kind == 2) ? faultEip : curEip;
    wrBefore = wrCount;
    evtValid = 1'b1;
    #1 chkEq("R1 hold while pending", 32'(holdIssue), 32'd1);
    @(negedge clk);
    evtValid = 1'b0;
    chkEq("R10 busy after accept", 32'(busy), 32'd1);
    cycles = 0;
    while (!done && cycles < 400) begin
      if (inject == 1 && cycles == 2) begin
        evtVector = 8'(g ^ 8'h81);
        evtValid = 1'b1;
      end
      if (inject == 1 && cycles == 3) evtValid = 1'b0;
      @(negedge clk);
      cycles++;
    end
    chkEq("R10 done reached", 32'(done), 32'd1);
    chkEq("R1 hold while busy", 32'(holdIssue), 32'd1);
    chkEq("R4 R5 gpFault", 32'(gpFault), 32'(gp));
    chkEq("R3 codeBase", codeBase, 32'h0001_0000 * 32'(segDpl + 1));
    if (gp) begin
      chkEq("R4 no writes", 32'(wrCount - wrBefore), 32'd0);
      chkEq("R4 cs kept", 32'(newCs), 32'(curCs));
      chkEq("R4 eip kept", newEip, curEip);
      chkEq("R4 ss kept", 32'(newSs), 32'(curSs));
      chkEq("R4 esp kept", newEsp, curEsp);
    end else begin
      nPush = 0;
      if (sw) begin
        items[0] = 32'(curSs);
        items[1] = curEsp;
        nPush = 2;
      end
      items[nPush] = curEflags;
      items[nPush + 1] = 32'(curCs);
      items[nPush + 2] = retEip;
      nPush += 3;
      if (errV) begin
        items[nPush] = errCode;
        nPush++;
      end
      chkEq("R7 write count", 32'(wrCount - wrBefore), 32'(nPush));
      for (int k = 0; k < nPush; k++) begin
        logic [31:0] a;
        a = startEsp - 32'(4 * (k + 1));
        chkEq("R6 R7 R8 stack word", mem[a[11:2]], items[k]);
      end
      chkEq("R9 newCs", 32'(newCs), 32'((((g & 3) + 1) << 3) | segDpl));
      chkEq("R2 R9 newEip", newEip, gateOff(g));
      chkEq("R6 R9 newSs", 32'(newSs), sw ? 32'(tssSs(segDpl)) : 32'(curSs));
      chkEq("R9 newEsp", newEsp, startEsp - 32'(4 * nPush));
    end
    if (inject == 2) evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    chkEq("R10 idle after done", 32'(busy), 32'd0);
    chkEq("R10 single done", 32'(done), 32'd0);
    if (inject == 2) begin
      @(negedge clk);
      chkEq("R10 event in done cycle ignored", 32'(busy | memReqValid), 32'd0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chkEq("R10 reset busy", 32'(busy), 32'd0);
    chkEq("R10 reset done", 32'(done), 32'd0);
    chkEq("R11 reset request", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 no hold when idle", 32'(holdIssue), 32'd0);
    for (int cpl = 0; cpl < 4; cpl++) begin
      stallMode = (cpl >= 2);
      for (int g = 0; g < 256; g++) begin
        runEvent(g, cpl, (g % 37 == 5) ? 1 : ((g % 41 == 7) ? 2 : 0));
      end
    end
    @(negedge clk);
    chkEq("R1 hold released", 32'(holdIssue), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule